// File: doc/BRIEF.md
# Four-Mode Serial Port

This block is a serial port for a small controller. One bank of control bits picks one of four modes. Mode 0 is a half-duplex synchronous shifter. In this mode the port is always the clock master: it drives the shift clock on `txd` and moves data both ways on the bidirectional data line, shown here as `rxd_in`, `rxd_out` and `rxd_oe`. Modes 1, 2 and 3 are framed asynchronous modes. Each frame has one start bit and one stop bit. The receiver oversamples each bit sixteen times and takes a majority vote.

Software talks to the port through a register-style write port with two addresses: control/status and data. Writing the data address starts a transmission. The control register holds the mode, receive enable, rate doubling, the ninth transmit bit, the interrupt enable, and the two flags TI and RI. Software clears the flags by writing the control register. An external timer supplies a one-cycle overflow strobe, which sets the bit timing in modes 1 and 3.

Top module: `serial_port`

## Requirements
- R1: After reset the control register reads 0x00, `txd` is 1, `rxd_oe` is 0 and `irq` is 0.
- R2: Control register layout is [1:0] mode, [2] receive enable, [3] double rate, [4] ninth transmit bit, [5] interrupt enable, [6] TI, [7] RI. The data address is selected by `reg_sel`=1.
- R3: In mode 0, a data write shifts 8 bits out on `rxd_out`, least significant bit first, with `rxd_oe` high. Each bit lasts 12 clocks. `txd` is low for the first 6 clocks of a bit and high for the last 6. TI is set at the end of the eighth bit.
- R4: In mode 0, reception starts when receive enable is 1 and RI is 0. The port samples `rxd_in` at each rising edge of `txd`, least significant bit first. After 8 bits, RI is set and the byte appears on `rbuf_q`.
- R5: While RI is set, no reception takes place. In mode 0 no shift clock is produced, and `rbuf_q` holds its value.
- R6: Mode 1 frames have 8 data bits. Each bit lasts 16 timer strobes. `rb8` receives the stop bit.
- R7: Mode 3 frames have 9 data bits at 16 timer strobes per bit. The ninth bit sent is control bit 4, and the ninth bit received goes to `rb8`.
- R8: Mode 2 frames have 9 data bits. A bit lasts 32 clocks when the double-rate bit is 1 and 64 clocks when it is 0.
- R9: The asynchronous receiver decides each bit by a 2-of-3 vote near mid-bit. A one-clock glitch is therefore ignored, and a low pulse that is gone by mid-bit is rejected as a false start.
- R10: `irq` is 1 exactly when the interrupt-enable bit is 1 and TI or RI is 1.
- R11: In the asynchronous modes, TI is set when the stop bit begins and RI is set at the middle of the stop bit. A control write of 0 clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control/status, 1 = data buffer |
| reg_wdata | input | 8 | Write data |
| ctl_q | output | 8 | Control/status register contents |
| rbuf_q | output | 8 | Last received byte |
| rb8 | output | 1 | Ninth received bit (stop bit in mode 1) |
| tmr_ovf | input | 1 | One-cycle timer overflow strobe |
| rxd_in | input | 1 | Data line as seen at the pad |
| rxd_out | output | 1 | Data line drive value (mode 0 transmit) |
| rxd_oe | output | 1 | Data line output enable |
| txd | output | 1 | Serial output, or shift clock in mode 0 |
| irq | output | 1 | Serial interrupt request |

## Verification
The hardest condition to reach from the ports is the 2-of-3 vote acting on a corrupted sample. The glitch must land on exactly one of the three mid-bit samples of a live frame, and the port gives no sign of when those samples happen. The bench drives a mode 2 frame by hand at the 32-clock rate and inverts every data bit for a single clock at the centre of the bit. That one-clock pulse cannot cover more than one of the samples, which are two clocks apart. Before that frame, the bench sends a short low pulse to trigger the false-start rejection path, and it confirms that RI stays clear.

// File: rtl/serial_port.sv
module serial_port #(
  parameter int M0_DIV = 12,
  parameter int OVS    = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_sel,
  input  logic [7:0] reg_wdata,
  output logic [7:0] ctl_q,
  output logic [7:0] rbuf_q,
  output logic       rb8,
  input  logic       tmr_ovf,
  input  logic       rxd_in,
  output logic       rxd_out,
  output logic       rxd_oe,
  output logic       txd,
  output logic       irq
);
  localparam int CW   = $clog2(M0_DIV);
  localparam int TKW  = $clog2(OVS);
  localparam int HALF = M0_DIV / 2;
  localparam int MID  = OVS / 2;

  logic [7:0] ctl;
  logic [1:0] mode;
  logic ren, dbl, tx8, ien, ti, ri, nine, is_async, wr_ctl, wr_dat;
  assign mode = ctl[1:0];
  assign ren = ctl[2];
  assign dbl = ctl[3];
  assign tx8 = ctl[4];
  assign ien = ctl[5];
  assign ti = ctl[6];
  assign ri = ctl[7];
  assign nine = mode[1];
  assign is_async = (mode != 2'd0);
  assign wr_ctl = reg_wr & ~reg_sel;
  assign wr_dat = reg_wr & reg_sel;

  logic [1:0] div;
  logic tick;
  logic [3:0] last_bit;
  assign tick = (mode == 2'd2) ? (dbl ? div[0] : &div) : tmr_ovf;
  assign last_bit = nine ? 4'd10 : 4'd9;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div <= '0;
    else        div <= div + 2'd1;

  // synchronous shift engine (mode 0)
  logic m0_busy, m0_tx;
  logic [CW-1:0] m0_ph;
  logic [2:0] m0_bit;
  logic [7:0] m0_sh;
  logic m0_end, m0_rise, m0_start_rx, m0_ri, m0_ti;
  assign m0_end  = m0_busy && (m0_ph == CW'(M0_DIV - 1));
  assign m0_rise = m0_busy && (m0_ph == CW'(HALF));
  assign m0_start_rx = !is_async && ren && !ri && !m0_busy && !wr_dat;
  assign m0_ri = !is_async && ren && m0_busy && !m0_tx && (m0_bit == 3'd7) && (m0_ph == CW'(HALF + 1));
  assign m0_ti = m0_end && m0_tx && (m0_bit == 3'd7);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m0_busy <= 1'b0; m0_tx <= 1'b0; m0_ph <= '0; m0_bit <= '0; m0_sh <= '0;
    end else if (!is_async && wr_dat) begin
      m0_busy <= 1'b1; m0_tx <= 1'b1; m0_ph <= '0; m0_bit <= '0; m0_sh <= reg_wdata;
    end else if (m0_start_rx) begin
      m0_busy <= 1'b1; m0_tx <= 1'b0; m0_ph <= '0; m0_bit <= '0;
    end else if (m0_busy) begin
      if (m0_end) begin
        m0_ph <= '0;
        if (m0_bit == 3'd7) m0_busy <= 1'b0;
        else                m0_bit <= m0_bit + 3'd1;
        if (m0_tx) m0_sh <= {1'b1, m0_sh[7:1]};
      end else begin
        m0_ph <= m0_ph + CW'(1);
      end
      if (!m0_tx && m0_rise) m0_sh <= {rxd_in, m0_sh[7:1]};
    end

  // asynchronous transmitter
  logic tx_busy;
  logic [10:0] tx_sh;
  logic [3:0] tx_bit;
  logic [TKW-1:0] tx_tk;
  logic tx_step, a_ti;
  assign tx_step = tx_busy && tick && (tx_tk == TKW'(OVS - 1));
  assign a_ti = tx_step && (tx_bit == last_bit - 4'd1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_busy <= 1'b0; tx_sh <= '1; tx_bit <= '0; tx_tk <= '0;
    end else if (is_async && wr_dat) begin
      tx_busy <= 1'b1; tx_bit <= '0; tx_tk <= '0;
      tx_sh <= {1'b1, nine ? tx8 : 1'b1, reg_wdata, 1'b0};
    end else if (tx_busy && tick) begin
      tx_tk <= tx_tk + TKW'(1);
      if (tx_step) begin
        tx_sh <= {1'b1, tx_sh[10:1]};
        if (tx_bit == last_bit) tx_busy <= 1'b0;
        else                    tx_bit <= tx_bit + 4'd1;
      end
    end

  // asynchronous receiver, 16x oversampled with 2-of-3 vote
  logic rx_q, rx_busy;
  logic [3:0] rx_bit;
  logic [TKW-1:0] rx_tk;
  logic [1:0] rx_v;
  logic [8:0] rx_sh;
  logic rx_dec, vote, a_ri;
  assign rx_dec = rx_busy && tick && (rx_tk == TKW'(MID + 1));
  assign vote = (rx_v[1] & rx_v[0]) | (rx_v[1] & rxd_in) | (rx_v[0] & rxd_in);
  assign a_ri = rx_dec && (rx_bit == last_bit) && !ri && ren;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_q <= 1'b1; rx_busy <= 1'b0; rx_bit <= '0; rx_tk <= '0; rx_v <= '0; rx_sh <= '0;
    end else begin
      rx_q <= rxd_in;
      if (!rx_busy) begin
        if (is_async && ren && rx_q && !rxd_in) begin
          rx_busy <= 1'b1; rx_bit <= '0; rx_tk <= '0;
        end
      end else if (tick) begin
        rx_tk <= rx_tk + TKW'(1);
        if (rx_tk == TKW'(MID - 1) || rx_tk == TKW'(MID)) rx_v <= {rx_v[0], rxd_in};
        if (rx_dec) begin
          if (rx_bit == 4'd0) begin
            if (vote) rx_busy <= 1'b0;
            else      rx_bit <= 4'd1;
          end else if (rx_bit == last_bit) begin
            rx_busy <= 1'b0;
          end else begin
            rx_sh <= {vote, rx_sh[8:1]};
            rx_bit <= rx_bit + 4'd1;
          end
        end
      end
    end

  // control/status and receive buffer
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctl <= '0; rbuf_q <= '0; rb8 <= 1'b0;
    end else begin
      if (wr_ctl) ctl <= reg_wdata;
      if (m0_ti || a_ti) ctl[6] <= 1'b1;
      if (m0_ri) begin
        ctl[7] <= 1'b1; rbuf_q <= m0_sh;
      end
      if (a_ri) begin
        ctl[7] <= 1'b1;
        rbuf_q <= nine ? rx_sh[7:0] : rx_sh[8:1];
        rb8 <= nine ? rx_sh[8] : vote;
      end
    end

  assign ctl_q = ctl;
  assign rxd_out = m0_sh[0];
  assign rxd_oe = !is_async && m0_busy && m0_tx;
  assign txd = !is_async ? !(m0_busy && (m0_ph < CW'(HALF))) : (tx_busy ? tx_sh[0] : 1'b1);
  assign irq = ien & (ti | ri);

  assert_ri_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ri && !wr_ctl) |=> ri);
  assert_rbuf_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ri && !wr_ctl) |=> $stable(rbuf_q));
  assert_ti_from_sender_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ti) && !$past(wr_ctl)) |-> $past(tx_busy || (m0_busy && m0_tx)));
  assert_ri_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ri) && !$past(wr_ctl)) |-> $past(ren));
  assert_no_clock_while_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && ri && !m0_busy && !wr_dat) |=> txd);
endmodule

// File: tb/tb_serial_port.sv
module tb_serial_port;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {mode[1:0], dbl, tx8, data[7:0]}; data[2:0] = 101 so bit 1 is an isolated low pulse
  localparam logic [11:0] VEC [NVEC] = '{
    {2'd1, 1'b0, 1'b0, 8'hA5}, {2'd1, 1'b0, 1'b0, 8'h35},
    {2'd3, 1'b0, 1'b1, 8'h6D}, {2'd3, 1'b0, 1'b0, 8'hFD},
    {2'd2, 1'b1, 1'b1, 8'h05}, {2'd2, 1'b0, 1'b0, 8'h8D},
    {2'd2, 1'b1, 1'b0, 8'hC5}, {2'd3, 1'b0, 1'b1, 8'h15}};

  logic clk = 0, rst_n = 0, reg_wr = 0, reg_sel = 0, tmr_ovf = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] ctl_q, rbuf_q;
  logic rb8, rxd_out, rxd_oe, txd, irq, rxd_in;
  logic loop = 0, drv = 1;
  logic [1:0] tcnt = 0;
  int nchk = 0, nbad = 0;
  bit done = 0;

  assign rxd_in = loop ? txd : (rxd_oe ? rxd_out : drv);

  serial_port dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ctl_q(ctl_q), .rbuf_q(rbuf_q), .rb8(rb8), .tmr_ovf(tmr_ovf),
    .rxd_in(rxd_in), .rxd_out(rxd_out), .rxd_oe(rxd_oe), .txd(txd), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) begin
    tcnt <= tcnt + 2'd1;
    tmr_ovf <= (tcnt == 2'd3);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic wait_rise(output int lowcnt);
    logic p;
    lowcnt = 0;
    forever begin
      if (!txd) lowcnt++;
      p = txd;
      @(negedge clk);
      if (!p && txd) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nbad++; nchk++;
      $display("FAIL watchdog: actual 0x1 expected 0x0");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin
    int lc, w, k;
    logic [7:0] cap;
    logic [11:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ctl_q == 8'h00, "R1 ctl", ctl_q, 0);
    chk(txd == 1'b1, "R1 txd", txd, 1);
    chk(rxd_oe == 1'b0, "R1 oe", rxd_oe, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);

    // R3 mode 0 transmit
    wr(0, 8'h00);
    wr(1, 8'h9C);
    cap = 0;
    for (int i = 0; i < 8; i++) begin
      wait_rise(lc);
      chk(lc == 6, "R3 clock low half", lc, 6);
      chk(rxd_oe == 1'b1, "R3 oe", rxd_oe, 1);
      cap[i] = rxd_out;
    end
    chk(cap == 8'h9C, "R3 byte lsb first", cap, 8'h9C);
    repeat (7) @(negedge clk);
    chk(ctl_q[6] == 1'b1, "R3 TI", ctl_q[6], 1);
    chk(rxd_oe == 1'b0, "R3 oe released", rxd_oe, 0);

    // R10 interrupt
    wr(0, 8'h60);
    chk(irq == 1'b1, "R10 irq on TI", irq, 1);
    wr(0, 8'h40);
    chk(irq == 1'b0, "R10 irq masked", irq, 0);

    // R4 mode 0 receive (R2 layout: ren is bit 2)
    wr(0, 8'h00);
    cap = 8'h6B;
    drv = cap[0];
    wr(0, 8'h04);
    for (int i = 0; i < 8; i++) begin
      wait_rise(lc);
      if (i < 7) begin
        while (txd) @(negedge clk);
        drv = cap[i+1];
      end
    end
    repeat (8) @(negedge clk);
    chk(ctl_q[7] == 1'b1, "R4 RI", ctl_q[7], 1);
    chk(rbuf_q == 8'h6B, "R4 byte", rbuf_q, 8'h6B);
    chk(ctl_q[6] == 1'b0, "R4 no TI", ctl_q[6], 0);
    wr(0, 8'hA4);
    chk(irq == 1'b1, "R10 irq on RI", irq, 1);

    // R5 blocked while RI set
    drv = 0;
    k = 0;
    repeat (100) begin @(negedge clk); if (!txd) k++; end
    chk(k == 0, "R5 no shift clock", k, 0);
    chk(rbuf_q == 8'h6B, "R5 buffer held", rbuf_q, 8'h6B);
    wr(0, 8'h00);
    chk(irq == 1'b0, "R10 irq cleared", irq, 0);
    drv = 1;

    // R6 R7 R8 R11 asynchronous loopback vectors
    for (int i = 0; i < NVEC; i++) begin
      v = VEC[i];
      loop = 1;
      wr(0, {3'b000, v[8], v[9], 1'b1, v[11:10]});
      wr(1, v[7:0]);
      while (txd) @(negedge clk);
      while (!txd) @(negedge clk);
      while (txd) @(negedge clk);
      w = 0;
      while (!txd) begin w++; @(negedge clk); end
      lc = (v[11:10] == 2'd2 && v[9]) ? 32 : 64;
      chk(w == lc, "R6/R7/R8 bit width", w, lc);
      k = 0;
      while (!ctl_q[7] && k < 4000) begin k++; @(negedge clk); end
      chk(ctl_q[7:6] == 2'b11, "R11 TI and RI", ctl_q[7:6], 3);
      chk(rbuf_q == v[7:0], "R6/R7 data", rbuf_q, v[7:0]);
      lc = (v[11:10] == 2'd1) ? 1 : int'(v[8]);
      chk(rb8 == lc[0], "R6/R7 rb8", rb8, lc);
      repeat (80) @(negedge clk);
      wr(0, 8'h00);
      chk(ctl_q[7:6] == 2'b00, "R11 flags cleared", ctl_q[7:6], 0);
    end
    loop = 0;

    // R9 false start and glitch rejection, mode 2 at 32 clocks per bit
    wr(0, 8'h0E);
    @(negedge clk); drv = 0;
    repeat (3) @(negedge clk);
    drv = 1;
    repeat (400) @(negedge clk);
    chk(ctl_q[7] == 1'b0, "R9 false start", ctl_q[7], 0);
    begin
      logic [10:0] fr;
      fr = {1'b1, 1'b1, 8'hB3, 1'b0};
      for (int b = 0; b < 11; b++)
        for (int c = 0; c < 32; c++) begin
          @(negedge clk);
          drv = (c == 16 && b >= 1 && b <= 9) ? ~fr[b] : fr[b];
        end
      @(negedge clk); drv = 1;
    end
    repeat (40) @(negedge clk);
    chk(ctl_q[7] == 1'b1, "R9 RI after glitched frame", ctl_q[7], 1);
    chk(rbuf_q == 8'hB3, "R9 vote data", rbuf_q, 8'hB3);
    chk(rb8 == 1'b1, "R9 vote ninth bit", rb8, 1);
    chk(ctl_q[1:0] == 2'd2, "R2 mode field", ctl_q[1:0], 2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule